// File: doc/BRIEF.md
# Pulse-Swallowing BCD Down Counter

This block counts a programmed number of fast input clocks, given as a two-digit decimal value. A divider with two moduli sits between the input clock and a pair of BCD down-counting digits, tens and units. Each divider output pulse lowers both digits by one in the same cycle. The divider runs at modulus 11 while the units digit is non-zero and at modulus 10 once it reaches zero. With this feedback the number of input clocks from load to completion equals the decimal preset (10·tens + units), and the slow digit logic only has to settle once per divider period.

A load strobe copies the two preset nibbles into the digits and restarts the divider from a known phase. When the tens digit reaches zero the block raises a completion flag, which stays high until the next load. A preset that cannot be counted this way is refused with an error flag. Such a preset has a nibble above 9, or a units digit larger than its tens digit.

Top module: `bcd_swallow_counter`

## Requirements
- R1: A synchronous active-high reset sets both digits to 0 and clears the completion and error flags. After reset both zero carries read 1.
- R2: A valid load (both nibbles 0..9, units ≤ tens) shows the preset on the digit outputs at the next clock edge. The divider phase restarts from zero, so a reload in the middle of a run counts from the new preset.
- R3: While the units carry is 0, both digits drop by one every 11 input clocks. modeSel reads 0 during this phase.
- R4: While the units carry is 1, the tens digit drops by one every 10 input clocks. modeSel reads 1 during this phase.
- R5: Completion rises on exactly the 10·tens + units-th clock edge after the load edge, on the same edge where the tens digit becomes 0.
- R6: A digit that is 0 holds at 0 when a divider pulse occurs. unitsCarry and tensCarry are 1 exactly when their digit is 0.
- R7: Once raised, completion stays high and the digits stay at 0,0 until the next load or reset.
- R8: A load with a nibble above 9 or units > tens raises presetErr and sets both digits to 0. Completion stays low, and nothing changes until the next load. A later valid load clears presetErr.
- R9: A valid load of 0,0 raises completion on the load edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being counted |
| rst | input | 1 | Synchronous active-high reset |
| presetEn | input | 1 | Load strobe for the preset digits |
| presetTens | input | 4 | Tens digit preset (BCD) |
| presetUnits | input | 4 | Units digit preset (BCD) |
| tensDigit | output | 4 | Current tens digit |
| unitsDigit | output | 4 | Current units digit |
| unitsCarry | output | 1 | Units digit is zero |
| tensCarry | output | 1 | Tens digit is zero |
| modeSel | output | 1 | Divider modulus select: 0 = /11, 1 = /10 |
| done | output | 1 | Programmed count of input clocks has elapsed |
| presetErr | output | 1 | Last load was refused |

## Verification
A divider phase that is off by one shows up at the first digit step. That step lands one edge early or late against the 11-clock boundary, so the bench samples each side of that edge. A wrong modulus selection adds or removes one clock per units step, and over a full run the completion edge drifts by that many clocks. The bench therefore checks the exact completion edge and the edge just before it. Digits that skip the hold at zero, or that fall out of step with each other, break the units ≤ tens relation at the outputs within one divider period. A stale error or completion flag is visible right after the following load.

// File: rtl/pswc_pkg.sv
package pswc_pkg;
  localparam int DIGIT_W = 4;
  localparam int DIGIT_MAX = 9;

  typedef struct packed {
    logic loadDigits;
    logic clearDigits;
    logic stepDigits;
  } pswStrobes_t;
endpackage

// File: rtl/pswc_digit.sv
module pswc_digit
  import pswc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  pswStrobes_t        strobes,
  input  logic [DIGIT_W-1:0] presetVal,
  output logic [DIGIT_W-1:0] digitVal,
  output logic               digitZero
);
  always_ff @(posedge clk) begin
    if (rst)                                    digitVal <= '0;
    else if (strobes.clearDigits)               digitVal <= '0;
    else if (strobes.loadDigits)                digitVal <= presetVal;
    else if (strobes.stepDigits && !digitZero)  digitVal <= digitVal - 1'b1;
  end

  assign digitZero = (digitVal == '0);

  // R6: a zero digit holds through a step
  p_zero_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (digitZero && !strobes.loadDigits) |=> digitZero);

  // R3: a step lowers a non-zero digit by exactly one
  p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
    (strobes.stepDigits && !digitZero && !strobes.loadDigits && !strobes.clearDigits)
      |=> (digitVal == $past(digitVal) - 1'b1));
endmodule

// File: rtl/pswc_datapath.sv
module pswc_datapath
  import pswc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  pswStrobes_t        strobes,
  input  logic [DIGIT_W-1:0] presetTens,
  input  logic [DIGIT_W-1:0] presetUnits,
  output logic [DIGIT_W-1:0] tensDigit,
  output logic [DIGIT_W-1:0] unitsDigit,
  output logic               unitsZero,
  output logic               tensZero,
  output logic               tensAtOne
);
  localparam int NUM_SECT = 2;

  logic [NUM_SECT-1:0][DIGIT_W-1:0] presetArr;
  logic [NUM_SECT-1:0][DIGIT_W-1:0] valArr;
  logic [NUM_SECT-1:0]              zeroArr;

  assign presetArr[0] = presetUnits;
  assign presetArr[1] = presetTens;

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    pswc_digit u_digit (
      .clk       (clk),
      .rst       (rst),
      .strobes   (strobes),
      .presetVal (presetArr[s]),
      .digitVal  (valArr[s]),
      .digitZero (zeroArr[s])
    );
  end

  assign unitsDigit = valArr[0];
  assign tensDigit  = valArr[1];
  assign unitsZero  = zeroArr[0];
  assign tensZero   = zeroArr[1];
  assign tensAtOne  = (valArr[1] == DIGIT_W'(1));

  // R8 / R2: sections move together, so units never exceeds tens
  p_units_le_tens_r8: assert property (@(posedge clk) disable iff (rst)
    unitsDigit <= tensDigit);
endmodule

// File: rtl/pswc_ctrl.sv
module pswc_ctrl
  import pswc_pkg::*;
#(
  parameter int DIV_BASE = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               presetEn,
  input  logic [DIGIT_W-1:0] presetTens,
  input  logic [DIGIT_W-1:0] presetUnits,
  input  logic               unitsZero,
  input  logic               tensZero,
  input  logic               tensAtOne,
  output pswStrobes_t        strobes,
  output logic               done,
  output logic               presetErr
);
  localparam int CW = $clog2(DIV_BASE + 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(DIV_BASE - 1);
  localparam logic [CW-1:0] LAST_LONG  = CW'(DIV_BASE);

  logic [CW-1:0] divCnt;
  logic          running;
  logic          presetOk;
  logic          divPulse;

  assign presetOk = (presetTens <= DIGIT_W'(DIGIT_MAX)) &&
                    (presetUnits <= DIGIT_W'(DIGIT_MAX)) &&
                    (presetUnits <= presetTens);

  assign divPulse = running && (unitsZero ? (divCnt == LAST_SHORT) : (divCnt == LAST_LONG));

  always_comb begin
    strobes.loadDigits  = presetEn && presetOk;
    strobes.clearDigits = presetEn && !presetOk;
    strobes.stepDigits  = !presetEn && divPulse;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt    <= '0;
      running   <= 1'b0;
      done      <= 1'b0;
      presetErr <= 1'b0;
    end else if (presetEn) begin
      divCnt    <= '0;
      presetErr <= !presetOk;
      running   <= presetOk && (presetTens != '0);
      done      <= presetOk && (presetTens == '0);
    end else if (running) begin
      if (divPulse) begin
        divCnt <= '0;
        if (tensAtOne) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // R3 / R4: divider never passes its long terminal count
  p_div_bound_r4: assert property (@(posedge clk) disable iff (rst)
    divCnt <= LAST_LONG);

  // R7: completion holds until a load
  p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !presetEn) |=> done);

  // R5: completion only with tens at zero
  p_done_tens_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> tensZero);

  // R8: a refusal holds until a load
  p_err_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (presetErr && !presetEn) |=> presetErr);

  // R8: refused state never completes
  p_err_no_done_r8: assert property (@(posedge clk) disable iff (rst)
    !(presetErr && done));
endmodule

// File: rtl/bcd_swallow_counter.sv
module bcd_swallow_counter
  import pswc_pkg::*;
#(
  parameter int DIV_BASE = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               presetEn,
  input  logic [DIGIT_W-1:0] presetTens,
  input  logic [DIGIT_W-1:0] presetUnits,
  output logic [DIGIT_W-1:0] tensDigit,
  output logic [DIGIT_W-1:0] unitsDigit,
  output logic               unitsCarry,
  output logic               tensCarry,
  output logic               modeSel,
  output logic               done,
  output logic               presetErr
);
  pswStrobes_t strobes;
  logic        unitsZero;
  logic        tensZero;
  logic        tensAtOne;

  pswc_ctrl #(.DIV_BASE(DIV_BASE)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .presetEn    (presetEn),
    .presetTens  (presetTens),
    .presetUnits (presetUnits),
    .unitsZero   (unitsZero),
    .tensZero    (tensZero),
    .tensAtOne   (tensAtOne),
    .strobes     (strobes),
    .done        (done),
    .presetErr   (presetErr)
  );

  pswc_datapath u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .presetTens  (presetTens),
    .presetUnits (presetUnits),
    .tensDigit   (tensDigit),
    .unitsDigit  (unitsDigit),
    .unitsZero   (unitsZero),
    .tensZero    (tensZero),
    .tensAtOne   (tensAtOne)
  );

  assign unitsCarry = unitsZero;
  assign tensCarry  = tensZero;
  assign modeSel    = unitsZero;
endmodule

// File: tb/bcd_swallow_counter_tb.sv
module bcd_swallow_counter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       presetEn = 1'b0;
  logic [3:0] presetTens = '0;
  logic [3:0] presetUnits = '0;
  logic [3:0] tensDigit, unitsDigit;
  logic       unitsCarry, tensCarry, modeSel, done, presetErr;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bcd_swallow_counter u_dut (
    .clk(clk), .rst(rst), .presetEn(presetEn),
    .presetTens(presetTens), .presetUnits(presetUnits),
    .tensDigit(tensDigit), .unitsDigit(unitsDigit),
    .unitsCarry(unitsCarry), .tensCarry(tensCarry),
    .modeSel(modeSel), .done(done), .presetErr(presetErr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chkState(input string req, input int t, input int u, input int dn, input int er);
    chk(req, "tens", tensDigit, t);
    chk(req, "units", unitsDigit, u);
    chk(req, "done", done, dn);
    chk(req, "err", presetErr, er);
  endtask

  task automatic doLoad(input int t, input int u);
    @(negedge clk);
    presetTens = 4'(t); presetUnits = 4'(u); presetEn = 1'b1;
    @(negedge clk);
    presetEn = 1'b0;
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk); rst = 1'b1;
    waitClk(2);
    rst = 1'b0;
    chkState("R1", 0, 0, 0, 0);
    chk("R1", "unitsCarry", unitsCarry, 1);
    chk("R1", "tensCarry", tensCarry, 1);
  endtask

  task automatic testExample();
    doLoad(3, 2);
    chkState("R2", 3, 2, 0, 0);
    chk("R3", "mode", modeSel, 0);
    waitClk(10);
    chkState("R3", 3, 2, 0, 0);
    waitClk(1);
    chkState("R3", 2, 1, 0, 0);
    chk("R3", "mode", modeSel, 0);
    waitClk(11);
    chkState("R6", 1, 0, 0, 0);
    chk("R4", "mode", modeSel, 1);
    chk("R6", "unitsCarry", unitsCarry, 1);
    chk("R6", "tensCarry", tensCarry, 0);
    waitClk(9);
    chkState("R4", 1, 0, 0, 0);
    waitClk(1);
    chkState("R5", 0, 0, 1, 0);
    chk("R6", "tensCarry", tensCarry, 1);
    waitClk(25);
    chkState("R7", 0, 0, 1, 0);
  endtask

  task automatic testTensOnly();
    doLoad(9, 0);
    chk("R4", "mode", modeSel, 1);
    waitClk(9);
    chkState("R4", 9, 0, 0, 0);
    waitClk(1);
    chkState("R4", 8, 0, 0, 0);
    waitClk(79);
    chkState("R5", 1, 0, 0, 0);
    waitClk(1);
    chkState("R5", 0, 0, 1, 0);
  endtask

  task automatic testEqualDigits();
    doLoad(5, 5);
    waitClk(54);
    chkState("R5", 1, 1, 0, 0);
    waitClk(1);
    chkState("R5", 0, 0, 1, 0);
  endtask

  task automatic testZeroPreset();
    doLoad(0, 0);
    chkState("R9", 0, 0, 1, 0);
    waitClk(15);
    chkState("R7", 0, 0, 1, 0);
  endtask

  task automatic testReject();
    doLoad(2, 5);
    chkState("R8", 0, 0, 0, 1);
    waitClk(30);
    chkState("R8", 0, 0, 0, 1);
    doLoad(10, 0);
    chkState("R8", 0, 0, 0, 1);
    doLoad(9, 12);
    chkState("R8", 0, 0, 0, 1);
    doLoad(1, 1);
    chkState("R8", 1, 1, 0, 0);
    waitClk(11);
    chkState("R8", 0, 0, 1, 0);
  endtask

  task automatic testReload();
    doLoad(3, 2);
    waitClk(7);
    doLoad(2, 1);
    chkState("R2", 2, 1, 0, 0);
    waitClk(10);
    chkState("R2", 2, 1, 0, 0);
    waitClk(1);
    chkState("R2", 1, 0, 0, 0);
    waitClk(10);
    chkState("R5", 0, 0, 1, 0);
  endtask

  task automatic testMidReset();
    doLoad(4, 3);
    waitClk(20);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chkState("R1", 0, 0, 0, 0);
    waitClk(50);
    chkState("R1", 0, 0, 0, 0);
  endtask

  initial begin
    testReset();
    testExample();
    testTensOnly();
    testEqualDigits();
    testZeroPreset();
    testReject();
    testReload();
    testMidReset();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule